// File: doc/BRIEF.md
# Dock Instruction Sequencer with Hatch

This block sits at the instruction side of a dock. Incoming 16-bit instruction words land in a small arrival buffer. The head of that buffer is the horn. From the horn they pass through a gate, the hatch, into a circular instruction queue. The head of that queue is the on-deck slot. A tail marker at the horn closes the hatch. While the hatch is closed, later words stay in the arrival buffer and form a loop epilogue. The hatch opens again whenever the outer loop counter is written with zero.

Outer-looping words (one-shot bit clear) are gated by the counter:
- While the counter is positive and the hatch is sealed, each one runs and then writes a copy of itself back into the queue.
- When the counter is zero, they are dropped.

One-shot words run once when their predicate holds. Counter-loading words are handled inside the block. Every other word that runs goes to an external execute unit through a valid/done handshake.

A separate torpedo input waits until the on-deck word can be interrupted. When it fires, the on-deck word is retired without a copy and the counter is zeroed. The execute side is also told to abandon the word and clear its inner repeat count.

Instruction word layout:
- `[15:13]` op: 000 move, 001 literal, 010 flag update, 011 inner count, 100 outer count load, 111 tail.
- `[12]` one-shot.
- `[11]` interruptible.
- `[10:9]` predicate.
- `[8:6]` for moves: token-in, data-in, data-out. For outer count loads, `[8:7]` is the mode: 00 decrement saturating at zero, 01 literal, 1x data input.
- `[5:0]` literal.

Top module: `dock_seq`

## Requirements
- R1: After reset the hatch is unsealed, the outer counter is 0, `ex_valid` is low and `in_ready` is high.
- R2: A tail word (op 111) at the horn seals the hatch, never enters the queue and is never presented on `ex_instr`.
- R3: While sealed, later words are held in the arrival buffer in order, and `in_ready` falls once that buffer holds PRE_DEPTH words.
- R4: An outer-looping word with a positive counter waits for the hatch to be sealed. It is then presented to the execute unit, and after `ex_done` it re-enters the queue tail, so it runs again on each pass.
- R5: An outer-looping word reaching on-deck with the counter at 0 is retired without being presented.
- R6: An outer count load with the one-shot bit set runs even with the counter at 0. It loads the counter with the saturating decrement, the 6-bit literal, or `olc_data`, according to its mode.
- R7: Whenever the counter is written with 0, by decrement, by load from data, or by torpedo, the hatch is unsealed.
- R8: A torpedo waits (`torp_ready` low) until the on-deck word is a move with the interruptible bit set, a true predicate, a positive counter and at least one of its three transfer bits set. It then fires for one cycle: the counter goes to 0, the hatch unseals, and the word is retired without a copy and without being presented.
- R9: Predicate codes: 11 always, 00 when `flag_a`, 10 when `flag_b`, 01 never. A word with a false predicate is not presented, and an outer-looping one is still requeued.
- R10: An outer count load with the one-shot bit clear is gated like any outer-looping word, so with the counter at 0 it leaves the counter unchanged.
- R11: A one-shot word other than a count load is presented once when its predicate holds, whatever the counter value, and is not requeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Arrival buffer has room |
| in_instr | input | 16 | Instruction word |
| torp_valid | input | 1 | Torpedo pending |
| torp_ready | output | 1 | Torpedo fires this cycle; execute side abandons and clears its repeat count |
| flag_a | input | 1 | Flag A for predicates |
| flag_b | input | 1 | Flag B for predicates |
| olc_data | input | CW | Data latch value for counter loads |
| ex_valid | output | 1 | On-deck word presented for execution |
| ex_instr | output | 16 | On-deck word |
| ex_done | input | 1 | Execute unit finished the presented word |
| sealed | output | 1 | Hatch state |
| olc | output | CW | Outer loop counter |

## Verification
The assertions assume the execute unit raises `ex_done` only while `ex_valid` is high. They also assume it tolerates `ex_valid` being withdrawn in the cycle a torpedo fires. The bench drives `ex_done` for exactly one cycle, and only after it has seen `ex_valid` together with the expected word. Torpedoes are raised only when the test is prepared to observe either a wait or a fire. `olc_data` changes only while no count load from data is at the on-deck slot.

// File: rtl/dock_seq.sv
module dock_seq #(
  parameter int PRE_DEPTH = 4,
  parameter int Q_DEPTH   = 4,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_instr,
  input  logic          torp_valid,
  output logic          torp_ready,
  input  logic          flag_a,
  input  logic          flag_b,
  input  logic [CW-1:0] olc_data,
  output logic          ex_valid,
  output logic [15:0]   ex_instr,
  input  logic          ex_done,
  output logic          sealed,
  output logic [CW-1:0] olc
);
  localparam int PW  = PRE_DEPTH > 1 ? $clog2(PRE_DEPTH) : 1;
  localparam int QW  = Q_DEPTH > 1 ? $clog2(Q_DEPTH) : 1;
  localparam int PCW = $clog2(PRE_DEPTH + 1);
  localparam int QCW = $clog2(Q_DEPTH + 1);
  localparam logic [2:0] OP_MOVE = 3'b000;
  localparam logic [2:0] OP_SETO = 3'b100;
  localparam logic [2:0] OP_TAIL = 3'b111;

  logic [15:0]    pre_mem [PRE_DEPTH];
  logic [PW-1:0]  pre_rd, pre_wr;
  logic [PCW-1:0] pre_cnt;
  logic [15:0]    q_mem [Q_DEPTH];
  logic [QW-1:0]  q_rd, q_wr;
  logic [QCW-1:0] q_cnt;

  logic [15:0] horn, hd;
  logic horn_v, horn_tail, horn_go, pre_push;
  logic hv, os, pred_ok, is_so, olc_pos, torpable, fire;
  logic dropped, ready_run, skip, so_go, finish, requeue, q_pop, q_push;
  logic olc_wr, zero_wr;
  logic [CW-1:0] so_val, olc_nxt;

  assign in_ready  = pre_cnt != PCW'(PRE_DEPTH);
  assign pre_push  = in_valid && in_ready;
  assign horn      = pre_mem[pre_rd];
  assign horn_v    = pre_cnt != '0;
  assign horn_tail = horn[15:13] == OP_TAIL;
  assign horn_go   = horn_v && !sealed && !zero_wr && (horn_tail || q_cnt != QCW'(Q_DEPTH));

  assign hd      = q_mem[q_rd];
  assign hv      = q_cnt != '0;
  assign os      = hd[12];
  assign is_so   = hd[15:13] == OP_SETO;
  assign olc_pos = olc != '0;

  always_comb begin
    case (hd[10:9])
      2'b11:   pred_ok = 1'b1;
      2'b00:   pred_ok = flag_a;
      2'b10:   pred_ok = flag_b;
      default: pred_ok = 1'b0;
    endcase
  end

  assign torpable  = hv && hd[15:13] == OP_MOVE && hd[11] && pred_ok && olc_pos && |hd[8:6];
  assign fire      = torp_valid && torpable;
  assign dropped   = hv && !fire && !os && !olc_pos;
  assign ready_run = hv && !fire && !dropped && (os || sealed);
  assign skip      = ready_run && !pred_ok;
  assign so_go     = ready_run && pred_ok && is_so;
  assign ex_valid  = ready_run && pred_ok && !is_so;
  assign ex_instr  = hd;
  assign finish    = skip || so_go || (ex_valid && ex_done);
  assign requeue   = finish && !os;
  assign q_pop     = fire || dropped || finish;
  assign q_push    = (horn_go && !horn_tail) || requeue;
  assign torp_ready = fire;

  assign so_val  = hd[8] ? olc_data : hd[7] ? CW'(hd[5:0]) : (olc_pos ? olc - 1'b1 : '0);
  assign olc_wr  = fire || so_go;
  assign olc_nxt = fire ? '0 : so_val;
  assign zero_wr = olc_wr && olc_nxt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_rd <= '0; pre_wr <= '0; pre_cnt <= '0;
      q_rd <= '0; q_wr <= '0; q_cnt <= '0;
      sealed <= 1'b0;
      olc <= '0;
    end else begin
      if (pre_push) begin
        pre_mem[pre_wr] <= in_instr;
        pre_wr <= (pre_wr == PW'(PRE_DEPTH - 1)) ? '0 : pre_wr + 1'b1;
      end
      if (horn_go) pre_rd <= (pre_rd == PW'(PRE_DEPTH - 1)) ? '0 : pre_rd + 1'b1;
      pre_cnt <= pre_cnt + PCW'(pre_push) - PCW'(horn_go);

      if (q_push) begin
        q_mem[q_wr] <= requeue ? hd : horn;
        q_wr <= (q_wr == QW'(Q_DEPTH - 1)) ? '0 : q_wr + 1'b1;
      end
      if (q_pop) q_rd <= (q_rd == QW'(Q_DEPTH - 1)) ? '0 : q_rd + 1'b1;
      q_cnt <= q_cnt + QCW'(q_push) - QCW'(q_pop);

      if (olc_wr) olc <= olc_nxt;
      if (zero_wr) sealed <= 1'b0;
      else if (horn_go && horn_tail) sealed <= 1'b1;
    end
  end

  a_r2_no_tail_exec: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> ex_instr[15:13] != OP_TAIL);
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= PCW'(PRE_DEPTH));
  a_r4_loop_needs_seal: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_instr[12]) |-> sealed);
  a_r5_no_loop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_instr[12]) |-> olc != '0);
  a_r7_zero_unseals: assert property (@(posedge clk) disable iff (!rst_n)
    (olc == '0 && $past(olc) != '0 && $past(rst_n)) |-> !sealed);
  a_r8_torp_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    torp_ready |=> (olc == '0 && !sealed));
  a_r8_torp_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
    torp_ready |-> !ex_valid);
endmodule

// File: tb/dock_seq_test.sv
module dock_seq_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [15:0] in_instr = '0;
  logic torp_valid = 0, torp_ready;
  logic flag_a = 0, flag_b = 0;
  logic [5:0] olc_data = '0;
  logic ex_valid, ex_done = 0;
  logic [15:0] ex_instr;
  logic sealed;
  logic [5:0] olc;
  int checks = 0, fails = 0;

  dock_seq uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .torp_valid(torp_valid), .torp_ready(torp_ready),
    .flag_a(flag_a), .flag_b(flag_b), .olc_data(olc_data), .ex_valid(ex_valid),
    .ex_instr(ex_instr), .ex_done(ex_done), .sealed(sealed), .olc(olc));

  always #10 clk = ~clk;

  function automatic logic [15:0] mk(input logic [2:0] op, input logic o, input logic i,
                                     input logic [1:0] p, input logic [2:0] b, input logic [5:0] l);
    return {op, o, i, p, b, l};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic send(input logic [15:0] w);
    in_valid = 1; in_instr = w;
    while (!in_ready) step();
    step();
    in_valid = 0;
  endtask

  task automatic expect_ex(input logic [15:0] exp, input string req);
    int n = 0;
    while (!ex_valid && n < 60) begin step(); n++; end
    chk(ex_valid && ex_instr == exp, req, {15'd0, ex_valid, ex_instr}, {16'd1, exp});
    ex_done = 1; step(); ex_done = 0;
  endtask

  task automatic expect_no_ex(input int n, input string req);
    logic seen = 0;
    for (int k = 0; k < n; k++) begin if (ex_valid) seen = 1; step(); end
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    chk(!sealed && olc == 0 && !ex_valid && in_ready, "R1 reset state",
        {sealed, olc, ex_valid, in_ready}, {1'b0, 6'd0, 1'b0, 1'b1});
  endtask

  task automatic t_loop();
    logic [15:0] a = mk(3'b000, 0, 0, 2'b11, 3'b000, 6'd1);
    logic [15:0] l = mk(3'b001, 1, 0, 2'b11, 3'b000, 6'd9);
    send(mk(3'b100, 1, 0, 2'b11, 3'b010, 6'd2));
    send(a);
    send(mk(3'b100, 0, 0, 2'b11, 3'b000, 6'd0));
    send(mk(3'b111, 0, 0, 2'b11, 3'b000, 6'd0));
    send(l);
    step(); step();
    chk(sealed, "R2 tail seals", sealed, 1);
    chk(olc == 2, "R6 literal load", olc, 2);
    expect_ex(a, "R4 first pass");
    expect_ex(a, "R4 requeued pass");
    expect_ex(l, "R11 epilogue after R5 drop (R2 R3 order)");
    chk(olc == 0 && !sealed, "R7 decrement to zero unseals", {olc, sealed}, 0);
    expect_no_ex(10, "R5 loop copies dropped");
  endtask

  task automatic t_torpedo_fire();
    logic [15:0] b = mk(3'b000, 0, 1, 2'b11, 3'b100, 6'd3);
    send(mk(3'b100, 1, 0, 2'b11, 3'b010, 6'd1));
    send(b);
    send(mk(3'b111, 0, 0, 2'b11, 3'b000, 6'd0));
    for (int k = 0; k < 4; k++) send(mk(3'b001, 1, 0, 2'b11, 3'b000, 6'(10 + k)));
    step();
    chk(!in_ready, "R3 arrival buffer full", in_ready, 0);
    chk(ex_valid && ex_instr == b, "R4 loop word presented", ex_instr, b);
    torp_valid = 1; #1;
    chk(torp_ready && !ex_valid, "R8 torpedo fires", {torp_ready, ex_valid}, 2'b10);
    step(); torp_valid = 0;
    chk(olc == 0 && !sealed, "R8 torpedo zeroes and unseals", {olc, sealed}, 0);
    for (int k = 0; k < 4; k++) expect_ex(mk(3'b001, 1, 0, 2'b11, 3'b000, 6'(10 + k)), "R3 R11 epilogue order");
  endtask

  task automatic t_torpedo_wait();
    logic [15:0] c = mk(3'b000, 0, 0, 2'b11, 3'b010, 6'd1);
    logic [15:0] d = mk(3'b000, 0, 1, 2'b11, 3'b010, 6'd2);
    logic waited = 1;
    int n = 0;
    send(mk(3'b100, 1, 0, 2'b11, 3'b010, 6'd3));
    send(c); send(d);
    send(mk(3'b111, 0, 0, 2'b11, 3'b000, 6'd0));
    while (!ex_valid && n < 60) begin step(); n++; end
    chk(ex_instr == c, "R4 non-interruptible on deck", ex_instr, c);
    torp_valid = 1;
    for (int k = 0; k < 4; k++) begin step(); if (torp_ready) waited = 0; end
    chk(waited && olc == 3, "R8 torpedo waits", {waited, olc}, {1'b1, 6'd3});
    ex_done = 1; step(); ex_done = 0; #1;
    chk(torp_ready && ex_instr == d && !ex_valid, "R8 fires on interruptible word",
        {torp_ready, ex_valid, ex_instr}, {2'b10, d});
    step(); torp_valid = 0;
    chk(olc == 0 && !sealed, "R7 torpedo unseals", {olc, sealed}, 0);
    expect_no_ex(10, "R8 torpedoed word not requeued");
  endtask

  task automatic t_pred();
    flag_a = 0; flag_b = 1;
    send(mk(3'b001, 1, 0, 2'b00, 3'b000, 6'd1));
    send(mk(3'b001, 1, 0, 2'b10, 3'b000, 6'd2));
    send(mk(3'b001, 1, 0, 2'b01, 3'b000, 6'd3));
    send(mk(3'b001, 1, 0, 2'b11, 3'b000, 6'd4));
    expect_ex(mk(3'b001, 1, 0, 2'b10, 3'b000, 6'd2), "R9 flag_b predicate");
    expect_ex(mk(3'b001, 1, 0, 2'b11, 3'b000, 6'd4), "R9 always predicate");
    expect_no_ex(6, "R9 false predicates skipped");
    flag_a = 1;
    send(mk(3'b001, 1, 0, 2'b00, 3'b000, 6'd5));
    expect_ex(mk(3'b001, 1, 0, 2'b00, 3'b000, 6'd5), "R9 flag_a predicate");
  endtask

  task automatic t_data_load();
    logic [15:0] e = mk(3'b000, 0, 0, 2'b11, 3'b000, 6'd5);
    olc_data = 6'd9;
    send(mk(3'b100, 1, 0, 2'b11, 3'b100, 6'd0));
    step(); step(); step();
    chk(olc == 9, "R6 load from data", olc, 9);
    olc_data = 6'd0;
    send(e);
    send(mk(3'b100, 0, 0, 2'b11, 3'b100, 6'd0));
    send(mk(3'b111, 0, 0, 2'b11, 3'b000, 6'd0));
    expect_ex(e, "R4 loop body");
    step(); step(); step();
    chk(olc == 0 && !sealed, "R7 data zero unseals", {olc, sealed}, 0);
    expect_no_ex(10, "R5 dropped at zero");
    send(mk(3'b100, 0, 0, 2'b11, 3'b010, 6'd7));
    repeat (5) step();
    chk(olc == 0, "R10 gated count load ignored", olc, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_loop();
    t_torpedo_fire();
    t_torpedo_wait();
    t_pred();
    t_data_load();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule